// File: doc/BRIEF.md
# Microwire EEPROM command master

This block turns single-word requests from on-chip logic into bit-serial instructions for a three-wire serial EEPROM. The device has a select line, a serial clock, a data line into the device and a data line out of it. A request names one of five commands: read, write, erase/write enable, erase/write disable and erase all. It also carries a byte address, write data and the memory organisation, which is either 8-bit or 16-bit words. From these the block builds the start bit, opcode and address field. It shifts write data out most significant bit first and collects read data from the device. Afterwards it waits a fixed time with select released: a short gap after most commands, and the programming time after a write or an erase-all. Then it pulses a completion flag, together with the read word.

Two device variations are chosen per request. One adds a dummy clock between the read address and the read data. The other appends two zero clocks to the enable, disable and erase-all instructions. A read-only input blocks every command that would change the memory. A multi-word transfer is built by the requester as a sequence of these commands, for example an enable, one write per word, and a disable.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While reset is asserted and after it is released, select and the serial clock are low, the request side is ready and no completion is flagged.
- R2: Command code 0 (read) sends a 1, then opcode bits 1,0, then the address field, all most significant bit first. The field has log2(SIZE_BYTES) bits holding the byte address in 8-bit organisation, or one bit fewer holding the byte address halved in 16-bit organisation. Then 8 or 16 more clocks follow, and the device data sampled on their rising edges is returned in the response, zero-extended in 8-bit organisation.
- R3: Command code 1 (write) sends a 1, opcode bits 0,1 and the address field as in R2, followed by 8 data bits (8-bit organisation, low byte of the write data) or 16 data bits, most significant first.
- R4: Command codes 2 (enable), 3 (disable) and 4 (erase all) send a 1, opcode bits 0,0 and an address field whose top two bits are 1,1 / 0,0 / 1,0 respectively and whose other bits are zero.
- R5: With the long-instruction option, the commands of R4 get two extra clocks carrying zero after the address field; read and write frames do not change.
- R6: With the extra-read-clock option, a read gets one extra clock carrying zero after the address, and the data clocks of R2 follow it.
- R7: Each bit lasts SK_HALF system cycles with the serial clock low, then SK_HALF cycles with it high. Data to the device changes only while the clock is low, select stays high for the whole frame, and the clock is never high while select is low.
- R8: After the last falling clock edge of a frame, select stays low for ceil(GAP_NS at CLK_HZ) cycles, or for PROG_US microseconds of cycles after a write or erase-all. Completion follows, so it rises 2*SK_HALF*N plus that many clock edges after the accepting edge, where N is the frame's clock count.
- R9: A write or erase-all while the read-only input is high, and any command code above 4, are refused. The completion and error flags rise on the accepting edge itself, and select never goes high. Read, enable and disable are carried out even when read-only is high.
- R10: Ready is high only while idle. A request offered while a command is in progress is not taken and leaves the frame on the wire unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to take a request |
| reqCmd | input | 3 | Command code: 0 read, 1 write, 2 enable, 3 disable, 4 erase all |
| reqAddr | input | ADDR_W | Byte address, ADDR_W = log2(SIZE_BYTES) |
| reqData | input | 16 | Write data (low byte used in 8-bit organisation) |
| orgWide | input | 1 | 1: 16-bit organisation, 0: 8-bit organisation |
| readOnly | input | 1 | Refuse write and erase all |
| optExtraRead | input | 1 | Dummy clock between read address and data |
| optLongInstr | input | 1 | Two trailing zero clocks on enable, disable, erase all |
| respDone | output | 1 | One-cycle completion pulse |
| respErr | output | 1 | With respDone: request refused |
| respData | output | 16 | Read word, valid with respDone |
| eeCs | output | 1 | Device select |
| eeSk | output | 1 | Serial clock |
| eeDo | output | 1 | Serial data to the device |
| eeDi | input | 1 | Serial data from the device |

## Verification
Every command's completion is due a fixed number of edges after the accepting edge: 2*SK_HALF*N plus the gap or programming wait, or no edges at all for a refused request. The bench computes N and the wait on its own from the requirements and counts falling clock edges from the accepting edge until completion. The count must equal that latency plus one, so both an early and a late pulse are caught. A behavioural device samples every bit on the rising serial clock, so the captured frame and its length are compared only after completion. The read word it drives is set up so that it changes right after a rising edge. Direct probes of select, the serial clock and the data line sit on the falling edges 1, SK_HALF and SK_HALF+1 after acceptance.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_EWEN  = 3'd2,
    CMD_EWDS  = 3'd3,
    CMD_ERAL  = 3'd4
  } cmd_e;

  // strobes from the control FSM to the shift datapath
  typedef struct packed {
    logic load;     // latch a new frame and raise select
    logic capture;  // copy the received word to the response register
  } dp_ctl_t;

endpackage

// File: rtl/uwire_frame.sv
module uwire_frame
  import uwire_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int FRAME_W = ADDR_W + 20,
  parameter int CLK_W   = $clog2(FRAME_W + 1)
) (
  input  logic [2:0]         cmd,
  input  logic               wide,
  input  logic               extraRead,
  input  logic               longInstr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [15:0]        wrData,
  output logic [FRAME_W-1:0] frame,
  output logic [CLK_W-1:0]   nClk
);

  int                 awEff;
  int                 dataW;
  int                 nBits;
  logic [ADDR_W-1:0]  wordAddr;
  logic [1:0]         spCode;
  logic [FRAME_W-1:0] val;

  always_comb begin
    awEff    = wide ? ADDR_W - 1 : ADDR_W;
    dataW    = wide ? 16 : 8;
    wordAddr = wide ? (addr >> 1) : addr;
    spCode   = 2'b00;
    val      = '0;
    nBits    = 1;
    case (cmd)
      CMD_READ: begin
        val   = (FRAME_W'(3'b110) << awEff) | FRAME_W'(wordAddr);
        nBits = 3 + awEff;
        if (extraRead) begin
          val   = val << 1;
          nBits = nBits + 1;
        end
        val   = val << dataW;
        nBits = nBits + dataW;
      end
      CMD_WRITE: begin
        val   = (FRAME_W'(3'b101) << awEff) | FRAME_W'(wordAddr);
        val   = (val << dataW) | FRAME_W'(wide ? wrData : {8'h00, wrData[7:0]});
        nBits = 3 + awEff + dataW;
      end
      CMD_EWEN, CMD_EWDS, CMD_ERAL: begin
        if (cmd == CMD_EWEN)      spCode = 2'b11;
        else if (cmd == CMD_ERAL) spCode = 2'b10;
        val   = (FRAME_W'(3'b100) << awEff) | (FRAME_W'(spCode) << (awEff - 2));
        nBits = 3 + awEff;
        if (longInstr) begin
          val   = val << 2;
          nBits = nBits + 2;
        end
      end
      default: begin
        val   = '0;
        nBits = 1;
      end
    endcase
    frame = val << (FRAME_W - nBits);
    nClk  = CLK_W'(nBits);
  end

endmodule

// File: rtl/uwire_datapath.sv
module uwire_datapath
  import uwire_pkg::*;
#(
  parameter int SK_HALF = 2,
  parameter int FRAME_W = 27,
  parameter int CLK_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctl_t            ctl,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CLK_W-1:0]   nClk,
  input  logic               wide,
  input  logic               sdi,
  output logic               csOut,
  output logic               skOut,
  output logic               sdo,
  output logic               shiftDone,
  output logic [15:0]        rdData
);

  localparam int DIV_W = $clog2(SK_HALF + 1);

  logic [FRAME_W-1:0] txSh;
  logic [15:0]        rxSh;
  logic [DIV_W-1:0]   halfCnt;
  logic [CLK_W-1:0]   bitsLeft;
  logic               wideQ;
  logic               halfEnd;

  assign halfEnd   = (halfCnt == DIV_W'(SK_HALF - 1));
  assign shiftDone = csOut && skOut && halfEnd && (bitsLeft == CLK_W'(1));
  assign sdo       = csOut && txSh[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '0;
      rxSh     <= '0;
      halfCnt  <= '0;
      bitsLeft <= '0;
      csOut    <= 1'b0;
      skOut    <= 1'b0;
      wideQ    <= 1'b0;
    end else if (ctl.load) begin
      txSh     <= frame;
      rxSh     <= '0;
      halfCnt  <= '0;
      bitsLeft <= nClk;
      csOut    <= 1'b1;
      skOut    <= 1'b0;
      wideQ    <= wide;
    end else if (csOut) begin
      if (halfEnd) begin
        halfCnt <= '0;
        if (!skOut) begin
          skOut <= 1'b1;
          rxSh  <= {rxSh[14:0], sdi};
        end else begin
          skOut    <= 1'b0;
          txSh     <= txSh << 1;
          bitsLeft <= bitsLeft - CLK_W'(1);
          if (bitsLeft == CLK_W'(1)) csOut <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= wideQ ? rxSh : {8'h00, rxSh[7:0]};
  end

  // R7: data to the device holds while the serial clock is high
  p_do_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    skOut |-> $stable(sdo));

  // R7: serial clock only toggles inside a selected frame
  p_sk_in_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    skOut |-> csOut);

endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
#(
  parameter int GAP_CYC  = 13,
  parameter int PROG_CYC = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqCmd,
  input  logic       readOnly,
  input  logic       shiftDone,
  input  logic       csOut,
  output logic       reqReady,
  output logic       respDone,
  output logic       respErr,
  output dp_ctl_t    ctl
);

  localparam int MAX_WAIT = (PROG_CYC > GAP_CYC) ? PROG_CYC : GAP_CYC;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_WAIT} state_e;

  state_e            state;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLim;
  logic              progQ;
  logic              accept;
  logic              isProg;
  logic              refuse;
  logic              waitEnd;

  assign reqReady    = (state == ST_IDLE);
  assign accept      = reqValid && reqReady;
  assign isProg      = (reqCmd == CMD_WRITE) || (reqCmd == CMD_ERAL);
  assign refuse      = (reqCmd > 3'd4) || (readOnly && isProg);
  assign waitLim     = progQ ? WAIT_W'(PROG_CYC - 1) : WAIT_W'(GAP_CYC - 1);
  assign waitEnd     = (state == ST_WAIT) && (waitCnt == waitLim);
  assign ctl.load    = accept && !refuse;
  assign ctl.capture = waitEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      progQ    <= 1'b0;
      respDone <= 1'b0;
      respErr  <= 1'b0;
    end else begin
      respDone <= 1'b0;
      respErr  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (refuse) begin
              respDone <= 1'b1;
              respErr  <= 1'b1;
            end else begin
              state <= ST_SHIFT;
              progQ <= isProg;
            end
          end
        end
        ST_SHIFT: begin
          if (shiftDone) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
          end
        end
        ST_WAIT: begin
          if (waitEnd) begin
            state    <= ST_IDLE;
            respDone <= 1'b1;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: select released for the whole gap / programming wait
  p_cs_low_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !csOut);

  // R9: refused request completes with error on the next cycle, no frame
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && refuse) |=> (respDone && respErr && !csOut));

  // R10: no select activity while idle
  p_idle_no_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !csOut);

  // R10: a request is only taken in the idle state
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && reqValid && !shiftDone) |=> (state == ST_SHIFT));

endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uwire_pkg::*;
#(
  parameter int SIZE_BYTES = 128,
  parameter int CLK_HZ     = 50_000_000,
  parameter int SK_HALF    = 2,
  parameter int GAP_NS     = 250,
  parameter int PROG_US    = 6000,
  localparam int ADDR_W    = $clog2(SIZE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqData,
  input  logic              orgWide,
  input  logic              readOnly,
  input  logic              optExtraRead,
  input  logic              optLongInstr,
  output logic              respDone,
  output logic              respErr,
  output logic [15:0]       respData,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDo,
  input  logic              eeDi
);

  localparam int FRAME_W  = ADDR_W + 20;
  localparam int CLK_W    = $clog2(FRAME_W + 1);
  localparam int GAP_CYC  = (CLK_HZ / 1000 * GAP_NS + 999_999) / 1_000_000;
  localparam int PROG_CYC = CLK_HZ / 1_000_000 * PROG_US;

  dp_ctl_t            ctl;
  logic [FRAME_W-1:0] frame;
  logic [CLK_W-1:0]   nClk;
  logic               shiftDone;

  uwire_frame #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .CLK_W(CLK_W)) uFrame (
    .cmd(reqCmd), .wide(orgWide), .extraRead(optExtraRead),
    .longInstr(optLongInstr), .addr(reqAddr), .wrData(reqData),
    .frame(frame), .nClk(nClk)
  );

  uwire_ctrl #(.GAP_CYC(GAP_CYC), .PROG_CYC(PROG_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .readOnly(readOnly), .shiftDone(shiftDone), .csOut(eeCs),
    .reqReady(reqReady), .respDone(respDone), .respErr(respErr), .ctl(ctl)
  );

  uwire_datapath #(.SK_HALF(SK_HALF), .FRAME_W(FRAME_W), .CLK_W(CLK_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .frame(frame), .nClk(nClk),
    .wide(orgWide), .sdi(eeDi), .csOut(eeCs), .skOut(eeSk), .sdo(eeDo),
    .shiftDone(shiftDone), .rdData(respData)
  );

endmodule

// File: tb/tb_uwire_eeprom_master.sv
`timescale 1ns/1ps
module tb_uwire_eeprom_master;

  localparam int HALF  = 2;
  localparam int GAP   = 13;   // ceil(250 ns * 50 MHz)
  localparam int PROG  = 100;  // 2 us * 50 MHz
  localparam int AW    = 7;    // 128 bytes

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [2:0] reqCmd = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic orgWide = 1'b0, readOnly = 1'b0, optExtraRead = 1'b0, optLongInstr = 1'b0;
  logic respDone, respErr;
  logic [15:0] respData;
  logic eeCs, eeSk, eeDo, eeDi;

  always #10 clk = ~clk;

  uwire_eeprom_master #(.SIZE_BYTES(128), .CLK_HZ(50_000_000), .SK_HALF(HALF),
                        .GAP_NS(250), .PROG_US(2)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqData(reqData), .orgWide(orgWide),
    .readOnly(readOnly), .optExtraRead(optExtraRead), .optLongInstr(optLongInstr),
    .respDone(respDone), .respErr(respErr), .respData(respData),
    .eeCs(eeCs), .eeSk(eeSk), .eeDo(eeDo), .eeDi(eeDi)
  );

  // behavioural device: records every bit, drives a read word
  logic [63:0] cap = '0;
  int capN = 0;
  int csRises = 0;
  int dStart = 0, dW = 0;
  logic [15:0] slvWord = '0;

  always @(posedge eeSk or posedge eeCs) begin
    if (eeSk) begin
      cap  <= {cap[62:0], eeDo};
      capN <= capN + 1;
    end else begin
      cap  <= '0;
      capN <= 0;
    end
  end
  always @(posedge eeCs) csRises <= csRises + 1;

  assign eeDi = (dW > 0 && capN >= dStart && capN < dStart + dW)
                ? slvWord[dW - 1 - (capN - dStart)] : 1'b0;

  int nChk = 0, nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  cmd;
    logic        wide;
    logic        xr;
    logic        li;
    logic [7:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [0:10] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 8'h55, 16'h00A5},  // read 8-bit
    '{3'd0, 1'b1, 1'b0, 1'b0, 8'h3A, 16'h1234},  // read 16-bit
    '{3'd0, 1'b1, 1'b1, 1'b0, 8'h7F, 16'hBEEF},  // read 16-bit, dummy clock
    '{3'd1, 1'b0, 1'b0, 1'b0, 8'h12, 16'hFF3C},  // write 8-bit
    '{3'd1, 1'b1, 1'b0, 1'b0, 8'h40, 16'hC0DE},  // write 16-bit
    '{3'd2, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000},  // enable 16-bit
    '{3'd3, 1'b0, 1'b0, 1'b0, 8'h7F, 16'hFFFF},  // disable 8-bit
    '{3'd4, 1'b1, 1'b0, 1'b1, 8'h00, 16'h0000},  // erase all, long
    '{3'd2, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000},  // enable 8-bit, long
    '{3'd0, 1'b0, 1'b1, 1'b1, 8'h01, 16'h0081},  // read 8-bit, dummy, long ignored
    '{3'd1, 1'b1, 1'b0, 1'b1, 8'h7E, 16'h5AA5}   // write 16-bit, long ignored
  };

  // expected frame built from the requirement text
  function automatic void expFrame(input logic [2:0] c, input logic w, input logic xr,
                                   input logic li, input logic [7:0] a, input logic [15:0] d,
                                   output logic [63:0] f, output int n, output int dwOut);
    int aw; int dw; logic [63:0] fld; logic [1:0] code;
    aw = w ? AW - 1 : AW;
    dw = w ? 16 : 8;
    fld = w ? 64'(a[6:1]) : 64'(a[6:0]);
    f = 64'd1; n = 1; dwOut = 0;
    case (c)
      3'd0: begin
        f = (f << 2) | 64'b10; f = (f << aw) | fld; n = n + 2 + aw;
        if (xr) begin f = f << 1; n = n + 1; end
        f = f << dw; n = n + dw; dwOut = dw;
      end
      3'd1: begin
        f = (f << 2) | 64'b01; f = (f << aw) | fld;
        f = (f << dw) | (w ? 64'(d) : 64'(d[7:0])); n = n + 2 + aw + dw;
      end
      default: begin
        code = (c == 3'd2) ? 2'b11 : (c == 3'd4) ? 2'b10 : 2'b00;
        f = (f << 2); f = (f << aw) | (64'(code) << (aw - 2)); n = n + 2 + aw;
        if (li) begin f = f << 2; n = n + 2; end
      end
    endcase
  endfunction

  // drive one request at a falling edge; lat = falling edges until completion
  task automatic issue(input logic [2:0] c, input logic w, input logic xr, input logic li,
                       input logic ro, input logic [7:0] a, input logic [15:0] d, output int lat);
    @(negedge clk);
    reqCmd = c; orgWide = w; optExtraRead = xr; optLongInstr = li;
    readOnly = ro; reqAddr = a[6:0]; reqData = d; reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    lat = -1;
    for (int i = 1; i <= 3000; i++) begin
      @(negedge clk);
      if (respDone) begin lat = i; break; end
    end
  endtask

  initial begin
    #4_000_000;
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [63:0] ef; int en; int edw; int lat; int csBefore;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk(eeCs == 0 && eeSk == 0, "R1 cs/sk low in reset", {eeCs, eeSk}, 0);
    chk(reqReady == 1 && respDone == 0, "R1 ready/done in reset", {reqReady, respDone}, 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(eeCs == 0 && eeSk == 0 && reqReady == 1 && respDone == 0, "R1 after reset",
        {eeCs, eeSk, reqReady, respDone}, 4'b0010);

    // table walk: R2 R3 R4 R5 R6 frames, R8 latency
    for (int v = 0; v < 11; v++) begin
      vec_t t;
      t = VECS[v];
      expFrame(t.cmd, t.wide, t.xr, t.li, t.addr, t.data, ef, en, edw);
      dStart = en - edw; dW = edw; slvWord = t.data;
      issue(t.cmd, t.wide, t.xr, t.li, 1'b0, t.addr, t.data, lat);
      chk(capN == en, "R2/R3/R4/R5/R6 frame length", 64'(capN), 64'(en));
      chk(cap == ef, "R2/R3/R4/R5/R6 frame bits", cap, ef);
      chk(lat == 2 * HALF * en + ((t.cmd == 3'd1 || t.cmd == 3'd4) ? PROG : GAP) + 1,
          "R8 completion latency", 64'(lat),
          64'(2 * HALF * en + ((t.cmd == 3'd1 || t.cmd == 3'd4) ? PROG : GAP) + 1));
      chk(respErr == 0, "R8 no error on legal command", 64'(respErr), 0);
      if (t.cmd == 3'd0)
        chk(respData == (t.wide ? t.data : {8'h00, t.data[7:0]}), "R2 read data",
            64'(respData), 64'(t.wide ? t.data : {8'h00, t.data[7:0]}));
      dW = 0;
    end

    // R9: write with read-only refused, no select activity
    csBefore = csRises;
    issue(3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 16'h00AA, lat);
    chk(lat == 1 && respErr == 1, "R9 write refused", {32'(lat), 31'd0, respErr}, {32'd1, 32'd1});
    chk(csRises == csBefore, "R9 no select on refused write", 64'(csRises), 64'(csBefore));
    issue(3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000, lat);
    chk(lat == 1 && respErr == 1, "R9 erase-all refused", {32'(lat), 31'd0, respErr}, {32'd1, 32'd1});
    issue(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, lat);
    chk(lat == 1 && respErr == 1, "R9 unknown code refused", {32'(lat), 31'd0, respErr}, {32'd1, 32'd1});
    chk(csRises == csBefore, "R9 no select on refusals", 64'(csRises), 64'(csBefore));
    // R9: read still served while read-only
    expFrame(3'd0, 1'b0, 1'b0, 1'b0, 8'h22, 16'h0069, ef, en, edw);
    dStart = en - edw; dW = edw; slvWord = 16'h0069;
    issue(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22, 16'h0000, lat);
    chk(respErr == 0 && respData == 16'h0069, "R9 read allowed when read-only",
        64'(respData), 64'h69);
    dW = 0;

    // R7 and R10: waveform probes and a request offered while busy
    expFrame(3'd3, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, ef, en, edw);
    @(negedge clk);
    reqCmd = 3'd3; orgWide = 1'b0; optExtraRead = 1'b0; optLongInstr = 1'b0;
    readOnly = 1'b0; reqAddr = '0; reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);
    chk(eeCs == 1 && eeSk == 0 && eeDo == 1, "R7 start bit with clock low",
        {eeCs, eeSk, eeDo}, 3'b101);
    for (int i = 1; i < HALF; i++) @(negedge clk);
    chk(eeSk == 0, "R7 clock low for half period", 64'(eeSk), 0);
    @(negedge clk);
    chk(eeSk == 1 && eeCs == 1, "R7 clock high after half period", {eeSk, eeCs}, 2'b11);
    reqCmd = 3'd4; reqValid = 1'b1;
    @(negedge clk);
    chk(reqReady == 0, "R10 not ready while busy", 64'(reqReady), 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    reqValid = 1'b0;
    lat = -1;
    for (int i = 1; i <= 3000; i++) begin
      @(negedge clk);
      if (respDone) begin lat = i; break; end
    end
    chk(lat > 0 && capN == en && cap == ef, "R10 busy request did not alter frame", cap, ef);
    csBefore = csRises;
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk(csRises == csBefore && reqReady == 1, "R10 busy request not taken later",
        64'(csRises), 64'(csBefore));

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule